// File: doc/BRIEF.md
# Register Shadow Stack Bank

This block holds a private, on-chip last-in first-out store for each architectural register of a core, such as the accumulator, two index registers and a status copy. When the core takes an interrupt, or runs an explicit save-all instruction, it raises one strobe and the current value of every register is captured in a single cycle. No memory traffic is involved. A matching restore strobe, raised on return from interrupt or by an explicit restore-all instruction, pops every register together. One cycle later the restored values appear on the outputs, marked by a one-cycle valid pulse. The service routine may therefore overwrite any register. Nested interrupts are supported up to the configured depth.

All per-register stores share one depth counter, so they always advance together. The stores are not visible to ordinary instructions. The core can see only the depth, the full and empty indications and three sticky error flags. A save when every slot is in use, a restore when nothing is held, and a save and a restore in the same cycle are all refused. A refused request leaves the stored contents and the depth untouched and sets its own sticky flag, which only reset clears.

Top module: `regshadow_stack`

## Requirements
- R1: After reset the depth is 0, `empty_o` is 1, `full_o` is 0, all three error flags are 0, `restore_valid_o` is 0 and `regs_o` is all zeros.
- R2: A save (`save_i`=1, `restore_i`=0) while depth < DEPTH captures every register lane of `regs_i` at once, and the depth rises by one at that clock edge.
- R3: A restore (`restore_i`=1, `save_i`=0) while depth > 0 makes `regs_o` equal to the most recent unrestored save, for every lane, in the cycle after the request edge. `restore_valid_o` is high for exactly that cycle, and the depth falls by one.
- R4: A save while depth = DEPTH is refused. The depth and the stored contents stay unchanged, and `overflow_o` becomes 1.
- R5: A restore while depth = 0 is refused. `regs_o` stays unchanged, `restore_valid_o` stays 0, and `underflow_o` becomes 1.
- R6: `save_i` and `restore_i` high in the same cycle are both ignored. The depth, the contents and `regs_o` stay unchanged, no valid pulse is produced, and `clash_o` becomes 1.
- R7: Filling all DEPTH slots and then restoring DEPTH times returns the saved vectors in exactly the reverse order of saving.
- R8: `full_o` is 1 exactly when depth = DEPTH, and `empty_o` is 1 exactly when depth = 0.
- R9: `regs_o` keeps the last restored vector until the next accepted restore.
- R10: `overflow_o`, `underflow_o` and `clash_o` stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| save_i | input | 1 | Save-all strobe (interrupt entry or explicit save instruction) |
| restore_i | input | 1 | Restore-all strobe (interrupt return or explicit restore instruction) |
| regs_i | input | NUM_REGS*REG_W | Current register values; lane k occupies bits [k*REG_W +: REG_W] |
| regs_o | output | NUM_REGS*REG_W | Restored register values, in the same lane layout |
| restore_valid_o | output | 1 | One-cycle pulse when `regs_o` holds newly restored values |
| depth_o | output | $clog2(DEPTH+1) | Number of saved frames |
| full_o | output | 1 | All slots in use |
| empty_o | output | 1 | No frame held |
| overflow_o | output | 1 | Sticky: a save was refused because the store was full |
| underflow_o | output | 1 | Sticky: a restore was refused because the store was empty |
| clash_o | output | 1 | Sticky: save and restore were requested together |

## Verification
The bench targets the edges of the shared counter: a save at exactly DEPTH frames, a restore at zero, and a full drain after a full fill. An off-by-one in the full compare would either lose the deepest frame or overwrite slot 0. A wrong read index would return the frame below the newest one. Simultaneous save and restore is driven at several depths, because a design that let one of them win would move the depth or emit a valid pulse. Refused restores are followed by idle cycles, so that a design that disturbs `regs_o` on a refused or absent restore is caught.

// File: rtl/shstk_pkg.sv
package shstk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_SAVE    = 2'd1,
        OP_RESTORE = 2'd2,
        OP_CLASH   = 2'd3
    } stk_op_e;

    function automatic stk_op_e decode_op(input logic save, input logic restore);
        unique case ({restore, save})
            2'b01:   return OP_SAVE;
            2'b10:   return OP_RESTORE;
            2'b11:   return OP_CLASH;
            default: return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/shstk_ctrl.sv
module shstk_ctrl
    import shstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_i,
    input  logic          restore_i,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output logic [PW-1:0] wr_idx_o,
    output logic [PW-1:0] rd_idx_o,
    output logic [DW-1:0] depth_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          valid_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          clash_o
);

    typedef struct packed {
        logic [DW-1:0] depth;
        logic          ovf;
        logic          unf;
        logic          clash;
        logic          valid;
    } ctrl_t;

    ctrl_t   st_d, st_q;
    stk_op_e op;
    logic    full, empty, take_save, take_restore;

    always_comb begin
        op           = decode_op(save_i, restore_i);
        full         = (st_q.depth == DW'(DEPTH));
        empty        = (st_q.depth == '0);
        take_save    = (op == OP_SAVE) && !full;
        take_restore = (op == OP_RESTORE) && !empty;

        st_d       = st_q;
        st_d.valid = take_restore;
        if (take_save)    st_d.depth = st_q.depth + DW'(1);
        if (take_restore) st_d.depth = st_q.depth - DW'(1);
        if ((op == OP_SAVE) && full)     st_d.ovf   = 1'b1;
        if ((op == OP_RESTORE) && empty) st_d.unf   = 1'b1;
        if (op == OP_CLASH)              st_d.clash = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o  = take_save;
    assign rd_en_o  = take_restore;
    assign wr_idx_o = PW'(st_q.depth);
    assign rd_idx_o = PW'(st_q.depth - DW'(1));
    assign depth_o  = st_q.depth;
    assign full_o   = full;
    assign empty_o  = empty;
    assign valid_o  = st_q.valid;
    assign ovf_o    = st_q.ovf;
    assign unf_o    = st_q.unf;
    assign clash_o  = st_q.clash;

    // R2: an accepted save raises the shared depth by one
    p_save_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && !full_o) |=> (depth_o == $past(depth_o) + DW'(1)));

    // R3: an accepted restore produces a valid pulse in the next cycle
    p_restore_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && !empty_o) |=> valid_o);

    // R4: a save at full depth leaves depth alone and raises overflow
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && full_o) |=> ($stable(depth_o) && ovf_o));

    // R5: a restore on an empty store gives no valid pulse
    p_empty_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && empty_o) |=> (!valid_o && unf_o));

    // R6: simultaneous requests are both dropped
    p_clash_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |=> ($stable(depth_o) && !valid_o && clash_o));

    // R8: depth never exceeds the configured number of slots
    p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(DEPTH));

    // R10: error flags are sticky
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o || unf_o || clash_o) |=> (($past(ovf_o) -> ovf_o) &&
                                         ($past(unf_o) -> unf_o) &&
                                         ($past(clash_o) -> clash_o)));

endmodule

// File: rtl/shstk_lane.sv
module shstk_lane #(
    parameter int REG_W = 16,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [PW-1:0]    wr_idx_i,
    input  logic [PW-1:0]    rd_idx_i,
    input  logic [REG_W-1:0] d_i,
    output logic [REG_W-1:0] q_o
);

    typedef struct packed {
        logic [DEPTH-1:0][REG_W-1:0] slots;
        logic [REG_W-1:0]            out;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (wr_en_i) ln_d.slots[wr_idx_i] = d_i;
        if (rd_en_i) ln_d.out = ln_q.slots[rd_idx_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign q_o = ln_q.out;

    // R9: the restored value is held while no restore is accepted
    p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(q_o));

    // R6: the control never asks a lane to write and read in one cycle
    p_no_dual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && rd_en_i));

endmodule

// File: rtl/regshadow_stack.sv
module regshadow_stack #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    parameter int DEPTH    = 8,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH),
    localparam int BUSW = NUM_REGS * REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic [BUSW-1:0] regs_i,
    output logic [BUSW-1:0] regs_o,
    output logic            restore_valid_o,
    output logic [DW-1:0]   depth_o,
    output logic            full_o,
    output logic            empty_o,
    output logic            overflow_o,
    output logic            underflow_o,
    output logic            clash_o
);

    logic          wr_en, rd_en;
    logic [PW-1:0] wr_idx, rd_idx;

    shstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_i   (save_i),
        .restore_i(restore_i),
        .wr_en_o  (wr_en),
        .rd_en_o  (rd_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .depth_o  (depth_o),
        .full_o   (full_o),
        .empty_o  (empty_o),
        .valid_o  (restore_valid_o),
        .ovf_o    (overflow_o),
        .unf_o    (underflow_o),
        .clash_o  (clash_o)
    );

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_lane
        shstk_lane #(.REG_W(REG_W), .DEPTH(DEPTH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (wr_en),
            .rd_en_i (rd_en),
            .wr_idx_i(wr_idx),
            .rd_idx_i(rd_idx),
            .d_i     (regs_i[k*REG_W +: REG_W]),
            .q_o     (regs_o[k*REG_W +: REG_W])
        );
    end

    // R8: full and empty are never reported together
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

endmodule

// File: tb/regshadow_stack_bench.sv
module regshadow_stack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_REGS   = 4;
    localparam int REG_W      = 16;
    localparam int DEPTH      = 8;
    localparam int DW         = $clog2(DEPTH + 1);
    localparam int BUSW       = NUM_REGS * REG_W;
    localparam int WATCHDOG   = 5000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            save_i = 1'b0, restore_i = 1'b0;
    logic [BUSW-1:0] regs_i = '0;
    logic [BUSW-1:0] regs_o;
    logic            restore_valid_o, full_o, empty_o;
    logic            overflow_o, underflow_o, clash_o;
    logic [DW-1:0]   depth_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference model
    logic [BUSW-1:0] m_stk[$];
    logic [BUSW-1:0] m_out;
    bit m_valid, m_ovf, m_unf, m_clash;

    regshadow_stack #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .DEPTH(DEPTH)) u_regshadow_stack (
        .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
        .regs_i(regs_i), .regs_o(regs_o), .restore_valid_o(restore_valid_o),
        .depth_o(depth_o), .full_o(full_o), .empty_o(empty_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o), .clash_o(clash_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [BUSW-1:0] act, input logic [BUSW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2/R3", "depth", BUSW'(depth_o), BUSW'(m_stk.size()));
        chk("R8", "full", BUSW'(full_o), BUSW'(m_stk.size() == DEPTH));
        chk("R8", "empty", BUSW'(empty_o), BUSW'(m_stk.size() == 0));
        chk("R3", "restore_valid", BUSW'(restore_valid_o), BUSW'(m_valid));
        chk("R9", "regs_o", regs_o, m_out);
        chk("R4", "overflow", BUSW'(overflow_o), BUSW'(m_ovf));
        chk("R5", "underflow", BUSW'(underflow_o), BUSW'(m_unf));
        chk("R6", "clash", BUSW'(clash_o), BUSW'(m_clash));
    endtask

    task automatic step(input bit s, input bit r, input logic [BUSW-1:0] v);
        save_i = s; restore_i = r; regs_i = v;
        @(posedge clk);
        m_valid = 0;
        if (s && r) m_clash = 1;
        else if (s) begin
            if (m_stk.size() == DEPTH) m_ovf = 1;
            else m_stk.push_back(v);
        end else if (r) begin
            if (m_stk.size() == 0) m_unf = 1;
            else begin m_out = m_stk.pop_back(); m_valid = 1; end
        end
        @(negedge clk);
        compare_all();
        save_i = 0; restore_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; save_i = 0; restore_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_stk.delete(); m_out = '0;
        m_valid = 0; m_ovf = 0; m_unf = 0; m_clash = 0;
        @(negedge clk);
    endtask

    function automatic logic [BUSW-1:0] pat(input int i);
        logic [BUSW-1:0] p;
        for (int k = 0; k < NUM_REGS; k++)
            p[k*REG_W +: REG_W] = REG_W'(16'hA000 + i * 16'h0111 + k * 16'h1003);
        return p;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [BUSW-1:0] lfsr;
        logic [BUSW-1:0] saved[DEPTH];
        do_reset();
        // R1: reset state
        chk("R1", "reset depth", BUSW'(depth_o), '0);
        chk("R1", "reset empty/full", BUSW'({empty_o, full_o}), BUSW'(2'b10));
        chk("R1", "reset flags", BUSW'({overflow_o, underflow_o, clash_o, restore_valid_o}), '0);
        chk("R1", "reset regs_o", regs_o, '0);

        // R2/R3: save three frames, restore one, save, restore rest
        step(1, 0, pat(1)); step(1, 0, pat(2)); step(1, 0, pat(3));
        step(0, 1, '0);
        chk("R3", "newest frame restored", regs_o, pat(3));
        step(0, 0, '1);
        step(1, 0, pat(4));
        step(0, 1, '0); step(0, 1, '0); step(0, 1, '0);
        chk("R3", "LIFO frame after mixed ops", regs_o, pat(1));

        // R5: restore from empty, then idle hold
        step(0, 1, '0);
        chk("R5", "underflow regs_o kept", regs_o, pat(1));
        step(0, 0, '0);
        chk("R9", "regs_o held after refused restore", regs_o, pat(1));

        // R6: clash at depth 0 and at depth 2
        step(1, 1, pat(9));
        step(1, 0, pat(5)); step(1, 0, pat(6));
        step(1, 1, pat(10));
        chk("R6", "clash keeps depth", BUSW'(depth_o), BUSW'(2));
        step(0, 1, '0);
        chk("R6", "clash stored nothing", regs_o, pat(6));
        step(0, 1, '0);

        // R7/R4: fill, push at full, drain in reverse
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            saved[i] = pat(20 + i);
            step(1, 0, saved[i]);
        end
        step(1, 0, pat(99));
        chk("R4", "overflow at full", BUSW'(overflow_o), BUSW'(1));
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(0, 1, '0);
            chk("R7", "reverse order drain", regs_o, saved[i]);
            step(0, 0, pat(50));
        end
        chk("R10", "overflow still set", BUSW'(overflow_o), BUSW'(1));

        // mixed pseudo-random traffic, compared every cycle
        lfsr = 64'h1234_5678_9ABC_DEF1;
        for (int c = 0; c < 600; c++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            step(lfsr[0] & ~lfsr[7], lfsr[1] & ~lfsr[8] | (lfsr[2] & lfsr[3]), lfsr);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule